// File: doc/BRIEF.md
# Timer Trigger Output Selector

This block sits beside a timer's counter and compare channels and turns the timer's internal events into two trigger lines that other timers or converters can listen to. Each line has its own mode field, held by the surrounding control logic, that chooses what the line carries. The choices include a software update strobe, the counter-enable level, the update (reload) event, a channel-1 compare match, or the level of one of the compare reference signals.

The secondary line has a wider mode field. It offers everything the primary line offers, plus the levels of two more compare references. It also offers a set of edge-combination modes, in which the line pulses on edges of one reference or on edges of a pair of references ORed together. Edges are detected against a registered copy of each reference. Both outputs are registered, so each output reflects the inputs sampled at the previous clock edge. Every pulse-type result is a single clock wide.

The block does not generate the compare references or the counter. It only decodes, detects edges and forms pulses.

Top module: `trgsel_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, both outputs are 0. The reference edge history follows the references during reset, so a reference that is already high when reset is released causes no edge pulse.
- R2: Each output is registered. The value present after clock edge k is the function of the inputs sampled at edge k, and of the references sampled at edge k-1.
- R3: Primary mode 0 gives a one-clock pulse for each cycle in which `sw_upd_i` is high.
- R4: Primary mode 1 gives the level of `cnt_en_i`.
- R5: Primary mode 2 gives a one-clock pulse for each cycle in which `upd_evt_i` is high, which yields a periodic trigger at the update rate.
- R6: Primary mode 3 gives a one-clock pulse for each cycle in which `cmp1_match_i` is high.
- R7: Primary modes 4, 5, 6 and 7 give the levels of compare references 1 to 4. Reference n is carried on `oc_ref_i[n-1]`.
- R8: Secondary modes 0 to 7 behave exactly as the primary modes with the same value. Secondary mode 8 gives the level of reference 5 (`oc_ref_i[4]`) and mode 9 gives the level of reference 6 (`oc_ref_i[5]`).
- R9: Secondary mode 10 gives a one-clock pulse on every rising or falling edge of reference 4. Mode 11 does the same for reference 6.
- R10: Secondary mode 12 pulses on a rising edge of reference 4 or a rising edge of reference 6. Mode 13 pulses on a rising edge of reference 4 or a falling edge of reference 6.
- R11: Secondary mode 14 pulses on a rising edge of reference 5 or a rising edge of reference 6. Mode 15 pulses on a rising edge of reference 5 or a falling edge of reference 6.
- R12: The two outputs are independent. Changing `sec_mode_i` has no effect on `trig_pri_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_upd_i | input | 1 | Software update strobe |
| upd_evt_i | input | 1 | Counter update (reload) event strobe |
| cnt_en_i | input | 1 | Counter-enable level |
| cmp1_match_i | input | 1 | Channel-1 compare match strobe |
| oc_ref_i | input | 6 | Compare references 1..6, bit n-1 is reference n |
| pri_mode_i | input | 3 | Primary trigger mode |
| sec_mode_i | input | 4 | Secondary trigger mode |
| trig_pri_o | output | 1 | Primary trigger output |
| trig_sec_o | output | 1 | Secondary trigger output |

## Verification
The bench goes after the release from reset with every reference already high. A design that cleared its edge history instead of loading it would fire a false edge pulse in the edge modes. It also walks every mode of both fields under pseudo-random stimulus in which references rise and fall on adjacent cycles. This catches a swapped rising and falling term in modes 13 and 15, or a wrong reference picked in the pair modes, as a pulse missing or present in one cycle. A final phase flips the secondary mode every cycle while the primary mode stays fixed. A decoder that shares or crosses the two fields would then disturb the primary line.

// File: rtl/trgsel_pkg.sv
package trgsel_pkg;

    localparam int NUM_REF   = 6;
    localparam int PRI_MW    = 3;
    localparam int SEC_MW    = 4;
    localparam int FULL_MW   = SEC_MW;

    typedef enum logic [FULL_MW-1:0] {
        SRC_SWUPD  = 4'd0,
        SRC_ENABLE = 4'd1,
        SRC_UPDATE = 4'd2,
        SRC_CMP1   = 4'd3,
        SRC_REF1   = 4'd4,
        SRC_REF2   = 4'd5,
        SRC_REF3   = 4'd6,
        SRC_REF4   = 4'd7,
        SRC_REF5   = 4'd8,
        SRC_REF6   = 4'd9,
        SRC_ANY4   = 4'd10,
        SRC_ANY6   = 4'd11,
        SRC_R4_R6  = 4'd12,
        SRC_R4_F6  = 4'd13,
        SRC_R5_R6  = 4'd14,
        SRC_R5_F6  = 4'd15
    } trg_src_e;

    typedef struct packed {
        logic sw_upd;
        logic cnt_en;
        logic upd;
        logic cmp1;
    } evt_t;

    typedef struct packed {
        logic [NUM_REF-1:0] lvl;
        logic [NUM_REF-1:0] rise;
        logic [NUM_REF-1:0] fall;
    } ref_t;

    // Index of reference n (1-based) inside the vectors
    localparam int IX4 = 3;
    localparam int IX5 = 4;
    localparam int IX6 = 5;

    function automatic logic trg_decode(trg_src_e src, evt_t ev, ref_t rf);
        logic res;
        case (src)
            SRC_SWUPD:  res = ev.sw_upd;
            SRC_ENABLE: res = ev.cnt_en;
            SRC_UPDATE: res = ev.upd;
            SRC_CMP1:   res = ev.cmp1;
            SRC_REF1:   res = rf.lvl[0];
            SRC_REF2:   res = rf.lvl[1];
            SRC_REF3:   res = rf.lvl[2];
            SRC_REF4:   res = rf.lvl[IX4];
            SRC_REF5:   res = rf.lvl[IX5];
            SRC_REF6:   res = rf.lvl[IX6];
            SRC_ANY4:   res = rf.rise[IX4] | rf.fall[IX4];
            SRC_ANY6:   res = rf.rise[IX6] | rf.fall[IX6];
            SRC_R4_R6:  res = rf.rise[IX4] | rf.rise[IX6];
            SRC_R4_F6:  res = rf.rise[IX4] | rf.fall[IX6];
            SRC_R5_R6:  res = rf.rise[IX5] | rf.rise[IX6];
            SRC_R5_F6:  res = rf.rise[IX5] | rf.fall[IX6];
            default:    res = 1'b0;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/trgsel_edge.sv
module trgsel_edge #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    logic [N-1:0] hist_q;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_bit
            // History follows the input even in reset so release gives no edge
            always_ff @(posedge clk) begin
                if (rst) hist_q[g] <= lvl_i[g];
                else     hist_q[g] <= lvl_i[g];
            end
            assign rise_o[g] =  lvl_i[g] & ~hist_q[g];
            assign fall_o[g] = ~lvl_i[g] &  hist_q[g];
        end
    endgenerate

endmodule

// File: rtl/trgsel_mux.sv
module trgsel_mux
    import trgsel_pkg::*;
#(
    parameter int MODE_W = 4
) (
    input  logic [MODE_W-1:0] mode_i,
    input  evt_t              evt_i,
    input  ref_t              ref_i,
    output logic              sel_o
);

    localparam int PAD_W = (MODE_W < FULL_MW) ? (FULL_MW - MODE_W) : 1;

    logic [FULL_MW-1:0] mode_full;

    generate
        if (MODE_W < FULL_MW) begin : g_narrow
            // Narrow field: zero-extend, so only the shared low modes exist
            logic [PAD_W-1:0] pad;
            assign pad       = '0;
            assign mode_full = {pad, mode_i};
        end else begin : g_wide
            assign mode_full = mode_i[FULL_MW-1:0];
        end
    endgenerate

    always_comb begin
        sel_o = trg_decode(trg_src_e'(mode_full), evt_i, ref_i);
    end

endmodule

// File: rtl/trgsel_top.sv
module trgsel_top
    import trgsel_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sw_upd_i,
    input  logic                  upd_evt_i,
    input  logic                  cnt_en_i,
    input  logic                  cmp1_match_i,
    input  logic [NUM_REF-1:0]    oc_ref_i,
    input  logic [PRI_MW-1:0]     pri_mode_i,
    input  logic [SEC_MW-1:0]     sec_mode_i,
    output logic                  trig_pri_o,
    output logic                  trig_sec_o
);

    evt_t evt;
    ref_t refs;
    logic pri_sel, sec_sel;

    assign evt.sw_upd = sw_upd_i;
    assign evt.cnt_en = cnt_en_i;
    assign evt.upd    = upd_evt_i;
    assign evt.cmp1   = cmp1_match_i;
    assign refs.lvl   = oc_ref_i;

    trgsel_edge #(.N(NUM_REF)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (oc_ref_i),
        .rise_o (refs.rise),
        .fall_o (refs.fall)
    );

    trgsel_mux #(.MODE_W(PRI_MW)) u_mux_pri (
        .mode_i (pri_mode_i),
        .evt_i  (evt),
        .ref_i  (refs),
        .sel_o  (pri_sel)
    );

    trgsel_mux #(.MODE_W(SEC_MW)) u_mux_sec (
        .mode_i (sec_mode_i),
        .evt_i  (evt),
        .ref_i  (refs),
        .sel_o  (sec_sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_pri_o <= 1'b0;
            trig_sec_o <= 1'b0;
        end else begin
            trig_pri_o <= pri_sel;
            trig_sec_o <= sec_sel;
        end
    end

    // R1: outputs quiet in the cycle after a reset edge
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!trig_pri_o && !trig_sec_o));

    // R4: enable mode follows the enable level one cycle later
    assert_enable_level_R4: assert property (@(posedge clk) disable iff (rst)
        (pri_mode_i == 3'd1) |=> (trig_pri_o == $past(cnt_en_i)));

    // R5: update event always produces a pulse in update mode
    assert_update_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        (pri_mode_i == 3'd2 && upd_evt_i) |=> trig_pri_o);

    // R9: no pulse when reference 4 holds still in any-edge mode
    assert_any4_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (sec_mode_i == 4'd10 && $stable(oc_ref_i[3])) |=> !trig_sec_o);

    // R10: rising edge of reference 6 pulses in mode 12
    assert_r6_rise_R10: assert property (@(posedge clk) disable iff (rst)
        (sec_mode_i == 4'd12 && $rose(oc_ref_i[5])) |=> trig_sec_o);

    // R11: no edge on references 5 and 6 means no pulse in mode 15
    assert_r5f6_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (sec_mode_i == 4'd15 && $stable(oc_ref_i[4]) && $stable(oc_ref_i[5]))
        |=> !trig_sec_o);

endmodule

// File: tb/tb_trgsel_top.sv
`timescale 1ns/1ps
module tb_trgsel_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sw_upd = 1'b0, upd_evt = 1'b0, cnt_en = 1'b0, cmp1 = 1'b0;
    logic [5:0] oc_ref = 6'h00;
    logic [2:0] pri_mode = 3'd0;
    logic [3:0] sec_mode = 4'd0;
    logic       trig_pri, trig_sec;

    always #4 clk = ~clk;   // 125 MHz

    trgsel_top dut (
        .clk          (clk),
        .rst          (rst),
        .sw_upd_i     (sw_upd),
        .upd_evt_i    (upd_evt),
        .cnt_en_i     (cnt_en),
        .cmp1_match_i (cmp1),
        .oc_ref_i     (oc_ref),
        .pri_mode_i   (pri_mode),
        .sec_mode_i   (sec_mode),
        .trig_pri_o   (trig_pri),
        .trig_sec_o   (trig_sec)
    );

    typedef struct {
        logic  ep;
        logic  es;
        string tp;
        string ts;
    } exp_t;

    exp_t       sb[$];
    int         total = 0;
    int         bad   = 0;
    logic [5:0] prev_ref = 6'h00;
    logic [31:0] lf = 32'h1ACE_B00C;
    bit         done = 0;

    // Reference model built from the requirements (R3..R11)
    function automatic logic model(int m, logic swu, logic en, logic up, logic c1,
                                   logic [5:0] r, logic [5:0] p);
        logic [5:0] ri, fa;
        ri = r & ~p;
        fa = ~r & p;
        case (m)
            0: return swu;
            1: return en;
            2: return up;
            3: return c1;
            4, 5, 6, 7, 8, 9: return r[m-4];
            10: return ri[3] | fa[3];
            11: return ri[5] | fa[5];
            12: return ri[3] | ri[5];
            13: return ri[3] | fa[5];
            14: return ri[4] | ri[5];
            default: return ri[4] | fa[5];
        endcase
    endfunction

    function automatic string tag_pri(int m);
        case (m)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic string tag_sec(int m);
        if (m <= 9)  return "R8";
        if (m <= 11) return "R9";
        if (m <= 13) return "R10";
        return "R11";
    endfunction

    // Driver: applies inputs at the falling edge and queues the expectation
    // for the next rising edge (R2: one register of latency)
    task automatic step(logic rr, logic swu, logic en, logic up, logic c1,
                        logic [5:0] r, logic [2:0] pm, logic [3:0] sm,
                        string tp, string ts);
        exp_t e;
        @(negedge clk);
        rst = rr; sw_upd = swu; cnt_en = en; upd_evt = up; cmp1 = c1;
        oc_ref = r; pri_mode = pm; sec_mode = sm;
        e.ep = rr ? 1'b0 : model(int'(pm), swu, en, up, c1, r, prev_ref);
        e.es = rr ? 1'b0 : model(int'(sm), swu, en, up, c1, r, prev_ref);
        e.tp = tp;
        e.ts = ts;
        prev_ref = r;
        sb.push_back(e);
    endtask

    // Monitor: pops one expectation per rising edge, sampled after the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                total++;
                if (trig_pri !== e.ep) begin
                    bad++;
                    $display("FAIL %s primary: actual=%b expected=%b", e.tp, trig_pri, e.ep);
                end
                total++;
                if (trig_sec !== e.es) begin
                    bad++;
                    $display("FAIL %s secondary: actual=%b expected=%b", e.ts, trig_sec, e.es);
                end
            end
        end
    end

    task automatic rnd_step(logic [2:0] pm, logic [3:0] sm, string tp, string ts);
        logic [5:0] r;
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        r  = prev_ref ^ (lf[5:0] & lf[11:6]);
        step(1'b0, lf[12] & lf[13], lf[14], lf[15] & lf[16], lf[17] & lf[18],
             r, pm, sm, tp, ts);
    endtask

    initial begin
        // R1: reset with every reference high, outputs quiet
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 6'h3F, 3'd1, 4'd10, "R1", "R1");
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 6'h3F, 3'd2, 4'd12, "R1", "R1");
        // R1: release with refs still high, no false edge in edge modes
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h3F, 3'd0, 4'd10, "R1", "R1");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h3F, 3'd0, 4'd11, "R1", "R1");

        // Directed: R10 / R11 rising versus falling of reference 6
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h1F, 3'd0, 4'd13, "R3", "R10");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h3F, 3'd0, 4'd13, "R3", "R10");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h1F, 3'd0, 4'd14, "R3", "R11");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h0F, 3'd0, 4'd15, "R3", "R11");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h1F, 3'd0, 4'd15, "R3", "R11");

        // Directed: R5 periodic update pulses
        for (int k = 0; k < 12; k++)
            step(1'b0, 1'b0, 1'b1, (k % 4) == 0, 1'b0, 6'h00, 3'd2, 4'd2, "R5", "R8");

        // Sweep every mode of both fields (R3..R11)
        for (int m = 0; m < 16; m++)
            for (int k = 0; k < 40; k++)
                rnd_step(3'(m % 8), 4'(m), tag_pri(m % 8), tag_sec(m));

        // R12: secondary mode flips every cycle, primary untouched
        for (int pm = 0; pm < 8; pm++)
            for (int k = 0; k < 20; k++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                rnd_step(3'(pm), lf[23:20], "R12", tag_sec(int'(lf[23:20])));
            end

        // R1: mid-run reset then recovery
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 6'h2A, 3'd1, 4'd1, "R1", "R1");
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'h2A, 3'd1, 4'd11, "R4", "R9");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h0A, 3'd1, 4'd11, "R4", "R9");

        @(negedge clk);
        @(negedge clk);
        done = 1;
    end

    initial begin
        wait (done);
        if (sb.size() != 0) begin
            bad++;
            $display("FAIL R2 scoreboard: actual=%0d expected=0 pending items", sb.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL R2 watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule